// File: doc/BRIEF.md
# Pad input debounce filter

This block cleans up one slow pad input before it reaches event detection. The raw pad level first passes through a synchronizer. It can then pass through an optional glitch stage that removes pulses only a clock or two wide. The last stage is a settle counter, which moves the output to a new level only after that level has been present, without a break, for a power-of-two number of base ticks. The base tick is supplied as a one-cycle enable. Its nominal period is 31.25 µs, so the shortest allowed setting gives 250 µs and the longest gives about 1.02 s.

A six-bit configuration word is loaded with a write strobe. It holds an enable, a four-bit exponent v that selects 2^v ticks, and a glitch-stage select. A write that enables the filter with an exponent below the minimum is refused, and the previous setting stays in force. When the filter is disabled, the synchronized input goes straight to the output. The pad input and the output are plain level signals sampled every clock, not transfers, so they carry no valid/ready handshake and there is no back-pressure.

Top module: `pad_debounce`

## Requirements
- R1: The configuration word is decoded as bit 0 = enable, bits [4:1] = exponent v, bit 5 = glitch select. An enabled filter needs 2^v base ticks to accept a new level, for every accepted v up to 15.
- R2: While enabled, the output changes only after the filtered input has differed from it on 2^v consecutive tick-enabled cycles. Cycles with the tick enable low neither count nor move the output.
- R3: A write with enable set and v below 3 is refused. The stored setting is kept, the output is not reloaded, and later settle times still use the old exponent.
- R4: A write with enable clear clears the enable, the exponent and the glitch select. The output then equals the pad input delayed by the two synchronizer flops.
- R5: If the filtered input returns to the current output level before the count completes, the count restarts from zero.
- R6: With glitch select set, a pulse of one clock on the synchronized input is removed and does not restart the count. A pulse of two clocks passes. The glitch stage adds two cycles of latency.
- R7: Every accepted write loads the output with the current synchronized input level and clears the counter, in the same cycle as the write.
- R8: Reset clears the configuration and drives the output low. After reset the block behaves as a disabled filter.
- R9: With the tick enable high on every clock, the output changes 2 + 2g + 2^v clock edges after the pad input changes, where g is 1 when glitch select is set and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle base-tick enable, nominally every 31.25 µs |
| pad_in | input | 1 | Raw asynchronous pad level |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 6 | Configuration word: [0] enable, [4:1] exponent, [5] glitch select |
| db_out | output | 1 | Debounced level |

## Verification
Two events can fall on the same clock edge: the settle counter reaching its final tick, and a configuration write arriving. The bench provokes this by issuing a refused write (exponent 1) on exactly the edge where a pending level change is due. It then expects the output to switch on that edge as if no write had happened. It also expects the next measured settle time to match the old exponent. A second collision has an accepted write land partway through a long count. There the reload must win, and the output must take the synchronized level on the write edge, well before the count could finish.

// File: rtl/pad_debounce_pkg.sv
package pad_debounce_pkg;

  localparam int DBC_EXP_W = 4;

  typedef struct packed {
    logic                 glitch;
    logic [DBC_EXP_W-1:0] exp;
    logic                 en;
  } dbc_cfg_t;

endpackage

// File: rtl/dbc_sync.sv
module dbc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/dbc_glitch.sv
module dbc_glitch #(
  parameter int MIN_CLKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic reload,
  input  logic din,
  output logic dout
);
  localparam int HW = MIN_CLKS - 1;

  logic [HW-1:0] hist_q;
  logic          level_q;
  logic          steady;

  assign steady = (hist_q == {HW{din}});

  generate
    if (HW == 1) begin : g_h1
      always_ff @(posedge clk) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= din;
      end
    end else begin : g_hn
      always_ff @(posedge clk) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= {hist_q[HW-2:0], din};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)                        level_q <= 1'b0;
    else if (reload)                   level_q <= din;
    else if (steady && din != level_q) level_q <= din;
  end

  assign dout = level_q;

  AST_SHORT_PULSE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!reload && !steady) |=> $stable(level_q)); // R6
endmodule

// File: rtl/dbc_cfg.sv
module dbc_cfg
  import pad_debounce_pkg::*;
#(
  parameter int EXP_MIN = 3
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr,
  input  dbc_cfg_t wdata,
  output dbc_cfg_t cfg,
  output logic     reload
);
  dbc_cfg_t cfg_q;
  logic     legal;

  assign legal  = !wdata.en || (int'(wdata.exp) >= EXP_MIN);
  assign reload = wr && legal;

  always_ff @(posedge clk) begin
    if (!rst_n)      cfg_q <= '0;
    else if (reload) cfg_q <= wdata.en ? wdata : '0;
  end

  assign cfg = cfg_q;

  AST_REJECT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && wdata.en && int'(wdata.exp) < EXP_MIN) |=> $stable(cfg_q)); // R3
  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !wdata.en) |=> (cfg_q == '0)); // R4
endmodule

// File: rtl/dbc_settle.sv
module dbc_settle
  import pad_debounce_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic [DBC_EXP_W-1:0] exp,
  input  logic                 tick,
  input  logic                 reload,
  input  logic                 din_sync,
  input  logic                 din_filt,
  output logic                 dout
);
  localparam int CNT_W = 2 ** DBC_EXP_W;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_cnt;
  logic             out_q;

  assign last_cnt = ~({CNT_W{1'b1}} << exp);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q <= 1'b0;
      cnt_q <= '0;
    end else if (reload || !en) begin
      out_q <= din_sync;
      cnt_q <= '0;
    end else if (din_filt == out_q) begin
      cnt_q <= '0;
    end else if (tick) begin
      if (cnt_q == last_cnt) begin
        out_q <= din_filt;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign dout = out_q;

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= last_cnt); // R2
  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !reload && !tick) |=> $stable(out_q)); // R2
  AST_RELOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> (out_q == $past(din_sync))); // R7
endmodule

// File: rtl/pad_debounce.sv
module pad_debounce
  import pad_debounce_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int GLITCH_CLKS = 2,
  parameter int EXP_MIN     = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_en,
  input  logic                 pad_in,
  input  logic                 cfg_wr,
  input  logic [DBC_EXP_W+1:0] cfg_wdata,
  output logic                 db_out
);
  dbc_cfg_t cfg;
  logic     reload;
  logic     pad_sync;
  logic     pad_clean;
  logic     pad_filt;
  logic     settled;

  dbc_cfg #(.EXP_MIN(EXP_MIN)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (cfg_wr),
    .wdata  (dbc_cfg_t'(cfg_wdata)),
    .cfg    (cfg),
    .reload (reload)
  );

  dbc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (pad_in),
    .dout  (pad_sync)
  );

  dbc_glitch #(.MIN_CLKS(GLITCH_CLKS)) u_glitch (
    .clk    (clk),
    .rst_n  (rst_n),
    .reload (reload),
    .din    (pad_sync),
    .dout   (pad_clean)
  );

  assign pad_filt = cfg.glitch ? pad_clean : pad_sync;

  dbc_settle u_settle (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (cfg.en),
    .exp      (cfg.exp),
    .tick     (tick_en),
    .reload   (reload),
    .din_sync (pad_sync),
    .din_filt (pad_filt),
    .dout     (settled)
  );

  assign db_out = cfg.en ? settled : pad_sync;

  AST_ENABLED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.en && !reload && !tick_en) |=> $stable(db_out)); // R2
endmodule

// File: tb/pad_debounce_test.sv
module pad_debounce_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b1;
  logic       pad_in = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [5:0] cfg_wdata = '0;
  logic       db_out;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pad_debounce uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .pad_in    (pad_in),
    .cfg_wr    (cfg_wr),
    .cfg_wdata (cfg_wdata),
    .db_out    (db_out)
  );

  localparam int NV = 10;
  localparam int V_EN [NV] = '{1, 1, 1, 1, 1, 1, 1, 1, 0, 1};
  localparam int V_EXP[NV] = '{3, 3, 4, 5, 3, 3, 3, 4, 0, 3};
  localparam int V_GL [NV] = '{0, 1, 0, 1, 0, 1, 1, 0, 0, 1};
  localparam int V_DAT[NV] = '{0, 0, 0, 0, 5, 5, 5, 10, 0, 0};
  localparam int V_DLN[NV] = '{0, 0, 0, 0, 1, 1, 2, 3, 0, 0};
  localparam int V_LAT[NV] = '{10, 12, 18, 36, 16, 12, 19, 31, 2, 12};

  task automatic check(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic write_cfg(input bit en, input int ex, input bit gl);
    cfg_wr    = 1'b1;
    cfg_wdata = {gl, 4'(ex), en};
    @(negedge clk);
    cfg_wr = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic measure(input int dip_at, input int dip_len, input int maxk, output int lat);
    logic ol;
    logic nl;
    ol  = db_out;
    nl  = ~ol;
    lat = -1;
    for (int k = 1; k <= maxk && lat < 0; k++) begin
      pad_in = (k > dip_at && k <= dip_at + dip_len) ? ol : nl;
      @(negedge clk);
      if (db_out === nl) lat = k;
    end
    pad_in = nl;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int lat;
    logic ol;
    logic nl;
    repeat (3) @(negedge clk);
    check("R8 output low in reset", int'(db_out), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 output low after reset", int'(db_out), 0);

    // Table walk: R1 R5 R6 R9 (and R4 passthrough in the disabled row)
    for (int i = 0; i < NV; i++) begin
      write_cfg(V_EN[i] != 0, V_EXP[i], V_GL[i] != 0);
      measure(V_DAT[i], V_DLN[i], 200, lat);
      check($sformatf("R9/R5/R6 vector %0d", i), lat, V_LAT[i]);
    end

    // R3: refused writes keep exponent 4
    write_cfg(1'b1, 4, 1'b0);
    write_cfg(1'b1, 2, 1'b0);
    write_cfg(1'b1, 0, 1'b1);
    measure(0, 0, 200, lat);
    check("R3 refused exponent kept", lat, 18);

    // R2: no tick, no progress; then 8 ticks
    write_cfg(1'b1, 3, 1'b0);
    tick_en = 1'b0;
    ol = db_out;
    pad_in = ~ol;
    repeat (50) @(negedge clk);
    check("R2 frozen without tick", int'(db_out), int'(ol));
    tick_en = 1'b1;
    lat = -1;
    for (int k = 1; k <= 40 && lat < 0; k++) begin
      @(negedge clk);
      if (db_out !== ol) lat = k;
    end
    check("R2 ticks counted", lat, 8);
    repeat (2) @(negedge clk);

    // Collision: refused write on the terminal edge (R3)
    write_cfg(1'b1, 3, 1'b0);
    ol = db_out;
    nl = ~ol;
    for (int k = 1; k <= 10; k++) begin
      pad_in = nl;
      if (k == 10) begin
        cfg_wr    = 1'b1;
        cfg_wdata = {1'b0, 4'd1, 1'b1};
      end
      @(negedge clk);
      cfg_wr = 1'b0;
      if (k == 9)  check("R3 collision not early", int'(db_out), int'(ol));
      if (k == 10) check("R3 collision switches on time", int'(db_out), int'(nl));
    end
    repeat (2) @(negedge clk);
    measure(0, 0, 200, lat);
    check("R3 setting kept after collision", lat, 10);

    // Collision: accepted write during a long count (R7)
    write_cfg(1'b1, 5, 1'b0);
    ol = db_out;
    nl = ~ol;
    pad_in = nl;
    repeat (10) @(negedge clk);
    check("R2 still counting", int'(db_out), int'(ol));
    cfg_wr    = 1'b1;
    cfg_wdata = {1'b0, 4'd3, 1'b1};
    @(negedge clk);
    cfg_wr = 1'b0;
    check("R7 reload takes input", int'(db_out), int'(nl));
    repeat (3) @(negedge clk);

    // R1: largest exponent
    write_cfg(1'b1, 15, 1'b0);
    measure(0, 0, 40000, lat);
    check("R1 exponent 15", lat, 32770);

    // R8: reset mid-run clears the configuration
    write_cfg(1'b1, 5, 1'b0);
    pad_in = 1'b1;
    rst_n  = 1'b0;
    repeat (2) @(negedge clk);
    check("R8 reset drives low", int'(db_out), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 R4 passthrough after reset", int'(db_out), 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule